// File: doc/BRIEF.md
# PCM Receive Timeslot Extractor

This block watches a serial PCM receive stream and picks out the one timeslot that software has chosen for its channel. It runs on the bit clock and samples the serial data and the frame-sync input on the falling edge. A programmable delay of 0 to 7 bit clocks sets where the frame really begins after frame sync. From that point the block counts bits and slots. When the chosen slot has fully arrived, it places the recovered sample on a parallel output and raises a one-clock strobe. A decoder downstream then takes the sample.

The block has two sample formats. In companded format each frame gives one 8-bit code. In linear format each frame gives one 16-bit word. The high byte of that word comes from the chosen slot and the low byte comes from the slot right after it. If the chosen slot is the last slot of the frame, the low byte is taken from slot 0 of the next frame. Each instance counts slots from its own frame-sync input, so several receive channels can be built from several instances.

Top module: `pcm_rx_slot_extractor`

## Requirements
- R1: While reset is asserted, and after it is released, `valid_o` is low and `sample_o` is zero until the first sample completes.
- R2: In companded format (`lin_mode`=0), with `slot_cfg[7]`=1, the 8 bits of slot N (`slot_cfg[6:0]`) are taken MSB first. Each slot is 8 bits long, and slot N covers frame bits 8N to 8N+7. The strobe follows the falling edge that samples bit 8N+7, and `sample_o` = {8'h00, code}.
- R3: Frame bit 0 is sampled on the falling edge that comes `frame_ofs` edges (0 to 7) after the edge where frame sync is first seen high.
- R4: In linear format (`lin_mode`=1), `sample_o` = {byte of slot N, byte of slot N+1}. The strobe follows the edge that samples frame bit 8N+15.
- R5: In linear format with N=127, no sample is given in that frame. The low byte is slot 0 of the next frame, and the strobe follows bit 7 of that frame.
- R6: With `slot_cfg[7]`=0 no strobe is raised and `sample_o` keeps its previous value.
- R7: `valid_o` is high for exactly one clock per completed sample. Once a sample is completed in a frame, no second strobe follows in that frame.
- R8: `sample_o` changes only in a cycle where `valid_o` is high, and it holds its value until the next strobe.
- R9: A rising edge on frame sync restarts the bit and slot count at once, even if the current frame is not finished.
- R10: Before the first frame sync is seen, nothing is captured, and no strobe is raised whatever the serial data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; serial data and frame sync are sampled on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame-sync input; a rising edge starts a frame |
| din | input | 1 | Serial PCM receive data, MSB first |
| slot_cfg | input | 8 | Bit 7: capture enable; bits 6..0: slot number 0 to 127 |
| lin_mode | input | 1 | 0: 8-bit companded sample, 1: 16-bit linear sample from two slots |
| frame_ofs | input | 3 | Bit clocks from frame sync to frame bit 0 |
| sample_o | output | 16 | Recovered sample, held between strobes |
| valid_o | output | 1 | One-clock strobe marking a newly completed sample |

## Verification
The assertions check several rules on every clock. The strobe is never longer than one cycle. The sample output never moves between strobes. No strobe appears while capture is disabled. A companded sample always has a zero upper byte. A linear sample only completes after its high byte has been stored. The bit counter starts at zero once the offset delay ends and then steps by one. Only the bench's frames can show the rest: that the correct slot's bits arrive in the correct order, that each of the eight offsets moves the strobe by exactly that many clocks, that the low byte wraps from slot 127 into the next frame, that a frame sync in the middle of a frame restarts the count, and that nothing is captured before any frame sync.

// File: rtl/pcm_rx_pkg.sv
`timescale 1ns/1ps
package pcm_rx_pkg;

    // Sample format chosen by the format input
    typedef enum logic {
        FMT_COMPANDED = 1'b0,
        FMT_LINEAR    = 1'b1
    } fmt_e;

endpackage

// File: rtl/pcm_rx_frame_align.sv
`timescale 1ns/1ps
// Frame-sync edge detection, start-offset delay and bit position counter.
// Gives the frame position of the bit sampled on the current falling edge.
module pcm_rx_frame_align #(
    parameter int SLOT_BITS = 8,
    parameter int NUM_SLOTS = 128,
    parameter int OFS_W     = 3
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              fsync,
    input  logic [OFS_W-1:0]                                  ofs,
    output logic                                              cur_act_o,
    output logic [$clog2(NUM_SLOTS)-1:0]                      cur_slot_o,
    output logic [$clog2(SLOT_BITS)-1:0]                      cur_bit_o
);
    localparam int SW    = $clog2(NUM_SLOTS);
    localparam int BW    = $clog2(SLOT_BITS);
    localparam int POS_W = SW + BW;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_SLOTS * SLOT_BITS - 1);

    typedef struct packed {
        logic             fs;
        logic [OFS_W-1:0] dly;
        logic             run;
        logic [POS_W-1:0] pos;
    } align_t;

    align_t st_q, st_d;
    logic             rise;
    logic             act;
    logic [POS_W-1:0] pos_now;

    always_comb begin
        st_d    = st_q;
        rise    = fsync & ~st_q.fs;
        act     = 1'b0;
        pos_now = '0;
        st_d.fs = fsync;
        if (rise) begin
            if (ofs == '0) begin
                act      = 1'b1;
                st_d.dly = '0;
            end else begin
                st_d.dly = ofs;
            end
        end else if (st_q.dly != '0) begin
            st_d.dly = st_q.dly - 1'b1;
            if (st_q.dly == OFS_W'(1)) begin
                act = 1'b1;
            end
        end else if (st_q.run && st_q.pos != LAST_POS) begin
            act     = 1'b1;
            pos_now = st_q.pos + 1'b1;
        end
        st_d.run = act;
        if (act) begin
            st_d.pos = pos_now;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_act_o  = act;
    assign cur_slot_o = pos_now[POS_W-1:BW];
    assign cur_bit_o  = pos_now[BW-1:0];

    // R3: once the offset delay runs out, the count sits at frame bit 0
    p_start_after_delay_r3: assert property (@(negedge clk) disable iff (!rst_n)
        ($past(st_q.dly) == OFS_W'(1) && !$past(rise)) |-> (st_q.run && st_q.pos == '0));

    // R2: within a frame the position advances by one per bit clock
    p_pos_step_r2: assert property (@(negedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run) && st_q.pos != '0) |-> (st_q.pos == $past(st_q.pos) + 1'b1));

endmodule

// File: rtl/pcm_rx_slot_capture.sv
`timescale 1ns/1ps
// Shifts in the selected slot(s) and assembles the companded or linear sample.
module pcm_rx_slot_capture
    import pcm_rx_pkg::*;
#(
    parameter int SLOT_BITS = 8,
    parameter int NUM_SLOTS = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          din,
    input  logic                          act,
    input  logic [$clog2(NUM_SLOTS)-1:0]  cur_slot,
    input  logic [$clog2(SLOT_BITS)-1:0]  cur_bit,
    input  logic                          en,
    input  logic [$clog2(NUM_SLOTS)-1:0]  sel_slot,
    input  logic                          lin,
    output logic [2*SLOT_BITS-1:0]        sample_o,
    output logic                          valid_o
);
    localparam int SW = $clog2(NUM_SLOTS);
    localparam int BW = $clog2(SLOT_BITS);
    localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_SLOTS - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(SLOT_BITS - 1);

    typedef struct packed {
        logic [SLOT_BITS-1:0]   sr;
        logic [SLOT_BITS-1:0]   hi;
        logic                   pend;
        logic [2*SLOT_BITS-1:0] out;
        logic                   val;
    } cap_t;

    cap_t st_q, st_d;
    fmt_e fmt;
    logic [SW-1:0]        nxt_slot;
    logic [SLOT_BITS-1:0] byte_now;
    logic                 in_first, in_second, last_bit;

    assign fmt = fmt_e'(lin);

    always_comb begin
        st_d      = st_q;
        st_d.val  = 1'b0;
        nxt_slot  = (sel_slot == LAST_SLOT) ? '0 : sel_slot + 1'b1;
        byte_now  = {st_q.sr[SLOT_BITS-2:0], din};
        last_bit  = (cur_bit == LAST_BIT);
        in_first  = act && en && (cur_slot == sel_slot);
        in_second = act && en && (fmt == FMT_LINEAR) && st_q.pend && (cur_slot == nxt_slot);

        if (!en || fmt == FMT_COMPANDED) begin
            st_d.pend = 1'b0;
        end
        if (in_first || in_second) begin
            st_d.sr = byte_now;
        end
        if (in_first && last_bit) begin
            if (fmt == FMT_LINEAR) begin
                st_d.hi   = byte_now;
                st_d.pend = 1'b1;
            end else begin
                st_d.out = {{SLOT_BITS{1'b0}}, byte_now};
                st_d.val = 1'b1;
            end
        end
        if (in_second && last_bit) begin
            st_d.out  = {st_q.hi, byte_now};
            st_d.val  = 1'b1;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o = st_q.out;
    assign valid_o  = st_q.val;

    // R7: strobe lasts one clock
    p_strobe_single_r7: assert property (@(negedge clk) disable iff (!rst_n)
        st_q.val |=> !st_q.val);

    // R8: output only moves with a strobe
    p_hold_between_r8: assert property (@(negedge clk) disable iff (!rst_n)
        !st_q.val |-> $stable(st_q.out));

    // R6: no strobe unless capture was enabled
    p_enable_gate_r6: assert property (@(negedge clk) disable iff (!rst_n)
        st_q.val |-> $past(en));

    // R2: companded samples carry a zero upper byte
    p_companded_upper_r2: assert property (@(negedge clk) disable iff (!rst_n)
        (st_q.val && !$past(lin)) |-> (st_q.out[2*SLOT_BITS-1:SLOT_BITS] == '0));

    // R4: a linear sample completes only after its high byte was stored
    p_linear_order_r4: assert property (@(negedge clk) disable iff (!rst_n)
        (st_q.val && $past(lin)) |-> $past(st_q.pend));

endmodule

// File: rtl/pcm_rx_slot_extractor.sv
`timescale 1ns/1ps
// Top: receive timeslot extractor for one PCM channel.
module pcm_rx_slot_extractor #(
    parameter int SLOT_BITS = 8,
    parameter int NUM_SLOTS = 128,
    parameter int OFS_W     = 3,
    localparam int SW       = $clog2(NUM_SLOTS),
    localparam int BW       = $clog2(SLOT_BITS)
) (
    input  logic                   bclk,
    input  logic                   rst_n,
    input  logic                   fsync,
    input  logic                   din,
    input  logic [SW:0]            slot_cfg,
    input  logic                   lin_mode,
    input  logic [OFS_W-1:0]       frame_ofs,
    output logic [2*SLOT_BITS-1:0] sample_o,
    output logic                   valid_o
);
    logic          act;
    logic [SW-1:0] cur_slot;
    logic [BW-1:0] cur_bit;

    pcm_rx_frame_align #(
        .SLOT_BITS (SLOT_BITS),
        .NUM_SLOTS (NUM_SLOTS),
        .OFS_W     (OFS_W)
    ) u_align (
        .clk        (bclk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .ofs        (frame_ofs),
        .cur_act_o  (act),
        .cur_slot_o (cur_slot),
        .cur_bit_o  (cur_bit)
    );

    pcm_rx_slot_capture #(
        .SLOT_BITS (SLOT_BITS),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_capture (
        .clk      (bclk),
        .rst_n    (rst_n),
        .din      (din),
        .act      (act),
        .cur_slot (cur_slot),
        .cur_bit  (cur_bit),
        .en       (slot_cfg[SW]),
        .sel_slot (slot_cfg[SW-1:0]),
        .lin      (lin_mode),
        .sample_o (sample_o),
        .valid_o  (valid_o)
    );

    // R1: nothing is flagged while held in reset
    p_reset_quiet_r1: assert property (@(negedge bclk) !rst_n |-> (!valid_o && sample_o == '0));

endmodule

// File: tb/pcm_rx_slot_extractor_test.sv
`timescale 1ns/1ps
module pcm_rx_slot_extractor_test;
    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        din = 1'b0;
    logic [7:0]  slot_cfg = 8'h00;
    logic        lin_mode = 1'b0;
    logic [2:0]  frame_ofs = 3'd0;
    logic [15:0] sample_o;
    logic        valid_o;

    int nchk = 0;
    int nerr = 0;
    int fr   = 0;
    int nval, vedge;
    logic [15:0] vdata;

    always #10 bclk = ~bclk;

    pcm_rx_slot_extractor uut (
        .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .din(din),
        .slot_cfg(slot_cfg), .lin_mode(lin_mode), .frame_ofs(frame_ofs),
        .sample_o(sample_o), .valid_o(valid_o)
    );

    function automatic logic [7:0] pat(input int f, input int s);
        return 8'((s * 37 + f * 101 + 13) ^ (s >> 2));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drives one frame: edge 0 carries frame sync (if fs_on), frame bit p on edge ofs+p.
    // Inputs change on rising edges; the design samples on falling edges.
    task automatic run_frame(input int f, input int len, input bit fs_on);
        logic [7:0] b;
        nval = 0; vedge = -1; vdata = '0;
        for (int i = 0; i < len + 2; i++) begin
            @(posedge bclk);
            if (i >= 1 && valid_o) begin
                if (nval == 0) begin
                    vedge = i - 1;
                    vdata = sample_o;
                end
                nval++;
            end
            fsync = fs_on && (i == 0);
            begin
                int p;
                p = i - int'(frame_ofs);
                if (i < len && p >= 0 && p < 1024) begin
                    b   = pat(f, p / 8);
                    din = b[7 - (p % 8)];
                end else begin
                    din = i[0] ^ i[3];
                end
            end
        end
    endtask

    initial begin
        #4000000;
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge bclk);
        check("R1 valid in reset", 32'(valid_o), 0);
        check("R1 sample in reset", 32'(sample_o), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge bclk);
        check("R1 sample after reset", 32'(sample_o), 0);

        // R10: data without frame sync
        slot_cfg = 8'h80; lin_mode = 1'b0; frame_ofs = 3'd0;
        run_frame(fr, 1100, 1'b0); fr++;
        check("R10 no strobe before sync", 32'(nval), 0);

        // R2/R3/R4/R7/R8: both formats, every offset
        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 8; o++) begin
                int s;
                logic [15:0] exp;
                s = (o * 29 + m * 3 + 1) % 127;
                slot_cfg = 8'h80 | 8'(s); lin_mode = m[0]; frame_ofs = 3'(o);
                run_frame(fr, o + 1024, 1'b1);
                exp = m ? {pat(fr, s), pat(fr, s + 1)} : {8'h00, pat(fr, s)};
                fr++;
                check(m ? "R7 linear strobe count" : "R7 companded strobe count", 32'(nval), 1);
                check(m ? "R3 R4 linear strobe edge" : "R3 R2 companded strobe edge",
                      32'(vedge), 32'(o + 8 * s + 7 + 8 * m));
                check(m ? "R4 linear sample" : "R2 companded sample", 32'(vdata), 32'(exp));
                check("R8 sample held after strobe", 32'(sample_o), 32'(exp));
            end
        end

        // R2: last slot, companded, offset 5
        slot_cfg = 8'hFF; lin_mode = 1'b0; frame_ofs = 3'd5;
        run_frame(fr, 5 + 1024, 1'b1);
        check("R2 slot 127 edge", 32'(vedge), 32'(5 + 1016 + 7));
        check("R2 slot 127 sample", 32'(vdata), 32'({8'h00, pat(fr, 127)}));
        fr++;

        // R5: linear wrap from slot 127 to slot 0 of next frame
        slot_cfg = 8'hFF; lin_mode = 1'b1; frame_ofs = 3'd2;
        run_frame(fr, 2 + 1024, 1'b1);
        check("R5 no strobe in first frame", 32'(nval), 0);
        run_frame(fr + 1, 2 + 1024, 1'b1);
        check("R5 one strobe in next frame", 32'(nval), 1);
        check("R5 wrap strobe edge", 32'(vedge), 32'(2 + 7));
        check("R5 wrap sample", 32'(vdata), 32'({pat(fr, 127), pat(fr + 1, 0)}));
        fr += 2;

        // R6: disabled capture leaves output alone
        begin
            logic [15:0] held;
            held = sample_o;
            slot_cfg = 8'h0A; lin_mode = 1'b0; frame_ofs = 3'd1;
            run_frame(fr, 1 + 1024, 1'b1); fr++;
            check("R6 no strobe when disabled", 32'(nval), 0);
            check("R6 sample unchanged", 32'(sample_o), 32'(held));
        end

        // R9: frame sync arrives before the frame ends
        slot_cfg = 8'h80 | 8'd60; lin_mode = 1'b0; frame_ofs = 3'd3;
        run_frame(fr, 300, 1'b1); fr++;
        check("R9 cut frame gives no strobe", 32'(nval), 0);
        run_frame(fr, 3 + 1024, 1'b1);
        check("R9 restart strobe edge", 32'(vedge), 32'(3 + 480 + 7));
        check("R9 restart sample", 32'(vdata), 32'({8'h00, pat(fr, 60)}));
        fr++;

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule